// File: doc/BRIEF.md
# Galloping and Walking Bit-RAM Self-Test Engine

This block is a built-in self-test sequencer for a single-bit-wide RAM of `WORDS` locations with a synchronous port. A read returns its data one clock after the request. After a start request the engine fills the memory with a background bit. It then moves a single complemented "base" cell through every address, reading the other cells against the background. In walking mode the base cell is re-read once at the end of each pass. In galloping mode it is re-read after every read of another cell. The whole sequence runs once with the chosen first background and again with its complement. Run time therefore grows with the square of the memory size.

The memory port is a plain enable/write-enable/address/data interface driven every cycle of a run. It has no back-pressure: the attached RAM must accept one operation per clock and return read data one cycle later. Every read result is compared with its expected bit. The first mismatch sets a sticky fail flag and captures the failing address and the bit that was expected. `busy` is high for the whole run, and `done` pulses for one cycle when the run ends.

Top module: `galwalk_bist`

## Requirements
- R1: After reset `busy`, `done`, `fail` and `mem_en` are 0.
- R2: A high `start` while idle launches a run on the next clock edge, latching `use_galpat` (1 = galloping, 0 = walking) and `bg_first`; `start` while `busy` is high has no effect on the operation stream or run length.
- R3: Each background phase begins by writing the background bit to every address from 0 upward, one write per cycle.
- R4: Base cells are taken in ascending address order; each base pass begins with a write of the complemented background to the base and ends with a write of the background back to it.
- R5: Walking mode: within a base pass, every other address is read in ascending order (skipping the base) expecting the background, then the base is read once expecting the complement.
- R6: Galloping mode: within a base pass, each read of another address (ascending, skipping the base) is followed at once by a read of the base expecting the complement.
- R7: The first phase uses background `bg_first` and the second its complement; a run therefore takes 2·N·(N+3) operation cycles in walking mode and 2·N·(2N+1) in galloping mode, one operation per cycle without gaps.
- R8: Read data is compared on the cycle after the read request; any mismatch sets `fail`, which stays high until the next launch.
- R9: `fail_addr` and `fail_exp` hold the address and expected bit of the first mismatching read of the run and are not changed by later mismatches.
- R10: `done` is high for exactly one cycle; in that cycle `busy` is already low and `fail` already includes the last read of the run.
- R11: `mem_en` is low whenever `busy` is low, and `mem_we` is high only together with `mem_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, honoured only while idle |
| use_galpat | input | 1 | 1 selects galloping, 0 selects walking |
| bg_first | input | 1 | Background bit of the first phase |
| mem_en | output | 1 | Memory operation valid this cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 1 | Write data |
| mem_rdata | input | 1 | Read data, valid one cycle after a read request |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | AW | Address of the first mismatch |
| fail_exp | output | 1 | Expected bit of the first mismatch |

## Verification
The first memory operation appears in the cycle after the edge that samples `start`. Each later operation follows one cycle after the previous one. `done` arrives exactly one cycle after the final restore write. The bench therefore counts clock edges from the launch edge and compares the operation seen in each cycle with a list computed arithmetically for that index. It also requires `done` at exactly index 2·N·(N+3) or 2·N·(2N+1). Fail results are read in the `done` cycle, because a comparison lands one edge after its read. The expected failing address and bit are derived from the injected stuck-cell or aliasing fault and from the background order.

// File: rtl/galwalk_pkg.sv
package galwalk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_SETB,
    ST_RDO,
    ST_RDB,
    ST_RSTR
  } gw_state_e;
endpackage

// File: rtl/galwalk_seq.sv
module galwalk_seq
  import galwalk_pkg::*;
#(
  parameter int WORDS = 16,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          use_galpat,
  input  logic          bg_first,
  output logic          launch,
  output logic          op_en,
  output logic          op_we,
  output logic [AW-1:0] op_addr,
  output logic          op_wdata,
  output logic          rd_req,
  output logic          rd_exp,
  output logic          busy,
  output logic          done
);
  localparam logic [AW:0] LAST = (AW+1)'(WORDS - 1);

  gw_state_e     state;
  logic [AW-1:0] base, oth;
  logic          bg, second, galp;

  logic [AW:0] nx1, nxt;
  logic        last_oth, last_base;

  // next non-base address above the current other-cell pointer
  always_comb begin
    nx1       = {1'b0, oth} + 1'b1;
    nxt       = (nx1 == {1'b0, base}) ? nx1 + 1'b1 : nx1;
    last_oth  = (nxt > LAST);
    last_base = ({1'b0, base} == LAST);
  end

  assign launch = (state == ST_IDLE) && start;
  assign busy   = (state != ST_IDLE);
  assign op_en  = busy;
  assign op_we  = (state == ST_FILL) || (state == ST_SETB) || (state == ST_RSTR);
  assign rd_req = (state == ST_RDO) || (state == ST_RDB);
  assign op_addr  = (state == ST_FILL || state == ST_RDO) ? oth : base;
  assign op_wdata = (state == ST_SETB) ? ~bg : bg;
  assign rd_exp   = (state == ST_RDB) ? ~bg : bg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      base   <= '0;
      oth    <= '0;
      bg     <= 1'b0;
      second <= 1'b0;
      galp   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          bg     <= bg_first;
          galp   <= use_galpat;
          second <= 1'b0;
          oth    <= '0;
          state  <= ST_FILL;
        end
        ST_FILL: begin
          if ({1'b0, oth} == LAST) begin
            base  <= '0;
            state <= ST_SETB;
          end else begin
            oth <= oth + 1'b1;
          end
        end
        ST_SETB: begin
          oth   <= (base == '0) ? AW'(1) : '0;
          state <= ST_RDO;
        end
        ST_RDO: begin
          if (galp) begin
            state <= ST_RDB;
          end else if (last_oth) begin
            state <= ST_RDB;
          end else begin
            oth <= nxt[AW-1:0];
          end
        end
        ST_RDB: begin
          if (galp && !last_oth) begin
            oth   <= nxt[AW-1:0];
            state <= ST_RDO;
          end else begin
            state <= ST_RSTR;
          end
        end
        ST_RSTR: begin
          if (!last_base) begin
            base  <= base + 1'b1;
            state <= ST_SETB;
          end else if (!second) begin
            second <= 1'b1;
            bg     <= ~bg;
            oth    <= '0;
            state  <= ST_FILL;
          end else begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/galwalk_cmp.sv
module galwalk_cmp #(
  parameter int WORDS = 16,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          rd_req,
  input  logic          rd_exp,
  input  logic [AW-1:0] rd_addr,
  input  logic          rdata,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic          fail_exp
);
  logic          pend_q, exp_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      exp_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      pend_q <= rd_req;
      exp_q  <= rd_exp;
      addr_q <= rd_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_exp  <= 1'b0;
    end else if (clear) begin
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_exp  <= 1'b0;
    end else if (pend_q && (rdata != exp_q) && !fail) begin
      fail      <= 1'b1;
      fail_addr <= addr_q;
      fail_exp  <= exp_q;
    end
  end
endmodule

// File: rtl/galwalk_bist.sv
module galwalk_bist #(
  parameter int WORDS = 16,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          use_galpat,
  input  logic          bg_first,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic          mem_wdata,
  input  logic          mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic          fail_exp
);
  logic launch, rd_req, rd_exp;

  galwalk_seq #(.WORDS(WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .use_galpat(use_galpat),
    .bg_first(bg_first), .launch(launch), .op_en(mem_en), .op_we(mem_we),
    .op_addr(mem_addr), .op_wdata(mem_wdata), .rd_req(rd_req),
    .rd_exp(rd_exp), .busy(busy), .done(done)
  );

  galwalk_cmp #(.WORDS(WORDS)) u_cmp (
    .clk(clk), .rst_n(rst_n), .clear(launch), .rd_req(rd_req),
    .rd_exp(rd_exp), .rd_addr(mem_addr), .rdata(mem_rdata),
    .fail(fail), .fail_addr(fail_addr), .fail_exp(fail_exp)
  );
endmodule

// File: rtl/galwalk_bist_chk.sv
module galwalk_bist_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          mem_en,
  input logic          mem_we,
  input logic          busy,
  input logic          done,
  input logic          fail,
  input logic [AW-1:0] fail_addr,
  input logic          fail_exp
);
  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
  a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !(start && !busy)) |=> fail);
  a_r9_first_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !(start && !busy)) |=> ($stable(fail_addr) && $stable(fail_exp)));
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en);
  a_r11_we_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);
  a_r2_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

bind galwalk_bist galwalk_bist_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mem_en(mem_en), .mem_we(mem_we),
  .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
  .fail_exp(fail_exp)
);

// File: tb/sim_galwalk_bist.sv
module sim_galwalk_bist;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 8;
  localparam int AW = $clog2(WORDS);
  localparam int MAXOPS = 1024;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, use_galpat = 1'b0, bg_first = 1'b0;
  logic mem_en, mem_we, mem_wdata, busy, done, fail, fail_exp;
  logic mem_rdata = 1'b0;
  logic [AW-1:0] mem_addr, fail_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  galwalk_bist #(.WORDS(WORDS)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .use_galpat(use_galpat),
    .bg_first(bg_first), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .fail(fail), .fail_addr(fail_addr), .fail_exp(fail_exp)
  );

  // memory model with optional fault: 0 none, 1 stuck cell, 2 write alias
  logic mem_q [WORDS];
  int   fkind = 0, fcell = 0, fdst = 0;
  logic fval = 1'b0;

  initial for (int i = 0; i < WORDS; i++) mem_q[i] = 1'b0;

  always @(posedge clk) begin
    if (mem_en && mem_we) begin
      mem_q[mem_addr] <= mem_wdata;
      if (fkind == 2 && int'(mem_addr) == fcell) mem_q[fdst] <= mem_wdata;
    end else if (mem_en) begin
      mem_rdata <= (fkind == 1 && int'(mem_addr) == fcell) ? fval : mem_q[mem_addr];
    end
  end

  int total = 0, failed = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  logic ewe [MAXOPS];
  int   eaddr [MAXOPS];
  logic edat [MAXOPS];
  int   elen;

  task automatic push(input logic we, input int a, input logic d);
    ewe[elen] = we; eaddr[elen] = a; edat[elen] = d; elen++;
  endtask

  task automatic build(input bit g, input bit b0);
    elen = 0;
    for (int k = 0; k < 2; k++) begin
      logic b;
      b = b0 ^ k[0];
      for (int a = 0; a < WORDS; a++) push(1'b1, a, b);
      for (int bs = 0; bs < WORDS; bs++) begin
        push(1'b1, bs, ~b);
        for (int o = 0; o < WORDS; o++) begin
          if (o != bs) begin
            push(1'b0, o, b);
            if (g) push(1'b0, bs, ~b);
          end
        end
        if (!g) push(1'b0, bs, ~b);
        push(1'b1, bs, b);
      end
    end
  endtask

  // one run; exp_fail/exp_addr/exp_bit derived from the injected fault
  task automatic run(input bit g, input bit b0, input int kind, input int c,
                     input logic v, input int dst, input int restart_at,
                     input bit check_clear);
    int n, bad, runlen;
    bit efail; int eaddr_f; logic ebit;
    fkind = kind; fcell = c; fval = v; fdst = dst;
    build(g, b0);
    runlen = g ? 2*WORDS*(2*WORDS+1) : 2*WORDS*(WORDS+3);
    efail = (kind != 0);
    eaddr_f = (kind == 1) ? c : dst;
    ebit = (kind == 1) ? ~v : b0;
    @(negedge clk);
    use_galpat = g; bg_first = b0; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    if (check_clear)
      check(fail == 1'b0, "R9", "fail cleared by launch", fail, 0);
    n = 0; bad = 0;
    forever begin
      if (n != 0) @(negedge clk);
      if (done) break;
      if (n >= MAXOPS) begin
        check(1'b0, "R7", "watchdog: run never ended", n, runlen);
        break;
      end
      if (!busy || !mem_en || mem_we != ewe[n] || int'(mem_addr) != eaddr[n] ||
          (ewe[n] && mem_wdata != edat[n])) bad++;
      start = (n == restart_at);
      n++;
    end
    start = 1'b0;
    check(bad == 0, g ? "R6" : "R5", "operation stream mismatches (R3 R4)", bad, 0);
    check(n == runlen, "R7", "run length", n, runlen);
    if (restart_at >= 0)
      check(n == runlen && bad == 0, "R2", "start while busy ignored", n, runlen);
    check(busy == 1'b0 && mem_en == 1'b0, "R10", "busy low with done", busy, 0);
    check(fail == efail, "R8", "fail flag", fail, efail);
    if (efail) begin
      check(int'(fail_addr) == eaddr_f, "R9", "first fail address", fail_addr, eaddr_f);
      check(fail_exp == ebit, "R9", "first fail expected bit", fail_exp, ebit);
    end
    @(negedge clk);
    check(done == 1'b0, "R10", "done one cycle", done, 0);
    check(mem_en == 1'b0, "R11", "memory idle after run", mem_en, 0);
    check(fail == efail, "R8", "fail held after run", fail, efail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && fail == 0 && mem_en == 0, "R1",
          "reset outputs", {busy, done, fail, mem_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && mem_en == 0, "R1", "idle after reset release", busy, 0);
    for (int g = 0; g < 2; g++) begin
      for (int b = 0; b < 2; b++) begin
        run(g[0], b[0], 0, 0, 1'b0, 0, (b == 0) ? 37 : -1, 1'b0);
        run(g[0], b[0], 1, 0, 1'b1, 0, -1, 1'b0);
        run(g[0], b[0], 1, 3, 1'b0, 0, -1, 1'b0);
        run(g[0], b[0], 1, 7, 1'b1, 0, -1, 1'b0);
        run(g[0], b[0], 2, 2, 1'b0, 5, -1, 1'b0);
        run(g[0], b[0], 2, 6, 1'b0, 1, -1, 1'b0);
        run(g[0], b[0], 0, 0, 1'b0, 0, -1, 1'b1);
      end
    end
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R7", "global watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule